// File: doc/BRIEF.md
# Operand Effective Address Unit

This sequential unit works out the 16-bit effective address of an instruction operand for an 8-bit processor core. The core pulses a start request with an addressing-mode code. With that request it supplies the address of the first operand byte, which is the byte that follows the opcode, and the current X and Y index values. The unit then reads the operand bytes through a byte-wide read port. When the mode calls for it, the unit also reads a two-byte pointer. It returns the effective address and the program counter advanced past the operand bytes.

Every read uses a request/ready handshake. The read data is taken in the same cycle that ready is high. While ready is low the unit holds its address and its state. A one-cycle done pulse marks the result as valid. The result stays on the outputs until the next accepted start.

Top module: `ea_unit`

## Requirements
- R1: After reset, and at any time between operations, busy_o, mem_req_o and done_o are low. A start_i that arrives while busy_o is high is ignored, and the operation in progress completes unchanged.
- R2: Mode codes 4 to 7 read two operand bytes. Every other code reads one. Operand bytes are read from pc_i upward. When done_o is high, pc_o equals pc_i plus the operand byte count, wrapped at 16 bits.
- R3: Codes 4, 5 and 6 (absolute, absolute+X, absolute+Y) form the base from the first byte as the low half and the second byte as the high half. Codes 5 and 6 add X or Y to the base with 16-bit wraparound.
- R4: Codes 1, 2 and 3 (zero page, zero page+X, zero page+Y) produce an address whose upper byte is 00. Codes 2 and 3 add X or Y to the byte with 8-bit wraparound, so FF plus 01 gives 0000.
- R5: Code 0 (immediate) gives ea_o = pc_i, which is the address of the operand byte itself.
- R6: Code 10 (relative) adds the operand byte, read as a signed two's-complement value, to pc_i+1. The sum wraps at 16 bits.
- R7: Code 7 (absolute indirect) reads the pointer low byte at the two-byte operand address and the pointer high byte at that address plus one, wrapped at 16 bits. ea_o is the pointer.
- R8: Code 8 (pre-indexed zero-page indirect) adds X to the operand byte modulo 256 to form a zero-page pointer location. It reads the low byte there and the high byte at the next location, modulo 256. ea_o is the pointer.
- R9: Code 9 (post-indexed zero-page indirect) reads the pointer at the operand byte and at the next location, modulo 256. ea_o is that pointer plus Y, wrapped at 16 bits.
- R10: While mem_req_o is high and mem_ready_i is low, the next cycle keeps mem_req_o high with mem_addr_o unchanged. Nothing advances.
- R11: done_o is high for exactly one cycle. With mem_ready_i held high, it rises N+1 cycles after the accepted start edge, where N is the number of reads. ea_o and pc_o keep their values until the next start.
- R12: Codes 11 to 15 behave exactly like immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted while idle |
| mode_i | input | 4 | Addressing-mode code |
| pc_i | input | 16 | Address of first operand byte |
| x_i | input | 8 | X index |
| y_i | input | 8 | Y index |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 16 | Read address |
| mem_ready_i | input | 1 | Read data valid this cycle |
| mem_rdata_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle result-valid pulse |
| ea_o | output | 16 | Effective address |
| pc_o | output | 16 | Program counter after the operand bytes |

## Verification
The checker watches the following on every cycle:
- the handshake hold during wait cycles;
- the single-cycle done pulse;
- quiet outputs while idle;
- the advanced PC for every mode;
- the zero upper byte of zero-page results;
- the immediate result.

Only the bench scenarios can show that the pointer reads wrap inside zero page and that little-endian assembly is correct. The same holds for the 8-bit and 16-bit index wraparound, the sign extension of the relative offset, a start ignored while busy, and the exact latency. To do this, the bench models memory as a computed byte function and compares ea_o and pc_o against independently derived values.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] AM_IMM  = 4'd0;
  localparam logic [MODE_W-1:0] AM_ZP   = 4'd1;
  localparam logic [MODE_W-1:0] AM_ZPX  = 4'd2;
  localparam logic [MODE_W-1:0] AM_ZPY  = 4'd3;
  localparam logic [MODE_W-1:0] AM_ABS  = 4'd4;
  localparam logic [MODE_W-1:0] AM_ABSX = 4'd5;
  localparam logic [MODE_W-1:0] AM_ABSY = 4'd6;
  localparam logic [MODE_W-1:0] AM_IND  = 4'd7;
  localparam logic [MODE_W-1:0] AM_IZX  = 4'd8;
  localparam logic [MODE_W-1:0] AM_IZY  = 4'd9;
  localparam logic [MODE_W-1:0] AM_REL  = 4'd10;

  typedef enum logic [1:0] {IDX_NONE, IDX_X, IDX_Y} idx_e;

  typedef struct packed {
    logic two_bytes;
    logic deref;
    logic ptr_zp;
    logic pre_x;
    idx_e post;
    logic zp_ea;
    logic imm;
    logic rel;
  } am_ctl_t;

  typedef enum logic [2:0] {S_IDLE, S_OP0, S_OP1, S_PTR0, S_PTR1, S_FIN} seq_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output am_ctl_t           ctl_o
);
  always_comb begin
    ctl_o = '0;
    ctl_o.post = IDX_NONE;
    unique case (mode_i)
      AM_ZP:   ctl_o.zp_ea = 1'b1;
      AM_ZPX:  begin ctl_o.zp_ea = 1'b1; ctl_o.post = IDX_X; end
      AM_ZPY:  begin ctl_o.zp_ea = 1'b1; ctl_o.post = IDX_Y; end
      AM_ABS:  ctl_o.two_bytes = 1'b1;
      AM_ABSX: begin ctl_o.two_bytes = 1'b1; ctl_o.post = IDX_X; end
      AM_ABSY: begin ctl_o.two_bytes = 1'b1; ctl_o.post = IDX_Y; end
      AM_IND:  begin ctl_o.two_bytes = 1'b1; ctl_o.deref = 1'b1; end
      AM_IZX:  begin ctl_o.deref = 1'b1; ctl_o.ptr_zp = 1'b1; ctl_o.pre_x = 1'b1; end
      AM_IZY:  begin ctl_o.deref = 1'b1; ctl_o.ptr_zp = 1'b1; ctl_o.post = IDX_Y; end
      AM_REL:  ctl_o.rel = 1'b1;
      default: ctl_o.imm = 1'b1;  // immediate and reserved codes
    endcase
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  am_ctl_t         ctl_i,
  input  logic [AW-1:0]   pc_start_i,
  input  logic [AW-1:0]   pc_cur_i,
  input  logic [DW-1:0]   b0_i,
  input  logic [DW-1:0]   b1_i,
  input  logic [DW-1:0]   p0_i,
  input  logic [DW-1:0]   p1_i,
  input  logic [DW-1:0]   x_i,
  input  logic [DW-1:0]   y_i,
  output logic [AW-1:0]   ptr_lo_o,
  output logic [AW-1:0]   ptr_hi_o,
  output logic [AW-1:0]   ea_o
);
  logic [DW-1:0] idx;
  logic [DW-1:0] zp_base;
  logic [DW-1:0] zp_next;
  logic [DW-1:0] zp_ea;
  logic [AW-1:0] abs_base;
  logic [AW-1:0] ptr;
  logic [AW-1:0] rel_off;

  always_comb begin
    unique case (ctl_i.post)
      IDX_X:   idx = x_i;
      IDX_Y:   idx = y_i;
      default: idx = '0;
    endcase
  end

  assign zp_base  = ctl_i.pre_x ? DW'(b0_i + x_i) : b0_i;
  assign zp_next  = DW'(zp_base + 1'b1);
  assign zp_ea    = DW'(b0_i + idx);
  assign abs_base = {b1_i, b0_i};
  assign ptr      = {p1_i, p0_i};
  assign rel_off  = {{DW{b0_i[DW-1]}}, b0_i};

  // pointer stays inside zero page for the zp-indirect forms
  assign ptr_lo_o = ctl_i.ptr_zp ? {{DW{1'b0}}, zp_base} : abs_base;
  assign ptr_hi_o = ctl_i.ptr_zp ? {{DW{1'b0}}, zp_next} : AW'(abs_base + 1'b1);

  always_comb begin
    if (ctl_i.imm)        ea_o = pc_start_i;
    else if (ctl_i.rel)   ea_o = AW'(pc_cur_i + rel_off);
    else if (ctl_i.deref) ea_o = AW'(ptr + {{DW{1'b0}}, idx});
    else if (ctl_i.zp_ea) ea_o = {{DW{1'b0}}, zp_ea};
    else                  ea_o = AW'(abs_base + {{DW{1'b0}}, idx});
  end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  input  am_ctl_t           ctl_i,
  input  logic [AW-1:0]     ptr_lo_i,
  input  logic [AW-1:0]     ptr_hi_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [AW-1:0]     pc_start_o,
  output logic [AW-1:0]     pc_cur_o,
  output logic [DW-1:0]     b0_o,
  output logic [DW-1:0]     b1_o,
  output logic [DW-1:0]     p0_o,
  output logic [DW-1:0]     p1_o,
  output logic [DW-1:0]     x_o,
  output logic [DW-1:0]     y_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_o     <= '0;
      pc_start_o <= '0;
      pc_cur_o   <= '0;
      b0_o       <= '0;
      b1_o       <= '0;
      p0_o       <= '0;
      p1_o       <= '0;
      x_o        <= '0;
      y_o        <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_o     <= mode_i;
          pc_start_o <= pc_i;
          pc_cur_o   <= pc_i;
          x_o        <= x_i;
          y_o        <= y_i;
          b0_o       <= '0;
          b1_o       <= '0;
          p0_o       <= '0;
          p1_o       <= '0;
          state_q    <= S_OP0;
        end
        S_OP0: if (mem_ready_i) begin
          b0_o     <= mem_rdata_i;
          pc_cur_o <= AW'(pc_cur_o + 1'b1);
          if (ctl_i.two_bytes)  state_q <= S_OP1;
          else if (ctl_i.deref) state_q <= S_PTR0;
          else                  state_q <= S_FIN;
        end
        S_OP1: if (mem_ready_i) begin
          b1_o     <= mem_rdata_i;
          pc_cur_o <= AW'(pc_cur_o + 1'b1);
          state_q  <= ctl_i.deref ? S_PTR0 : S_FIN;
        end
        S_PTR0: if (mem_ready_i) begin
          p0_o    <= mem_rdata_i;
          state_q <= S_PTR1;
        end
        S_PTR1: if (mem_ready_i) begin
          p1_o    <= mem_rdata_i;
          state_q <= S_FIN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = pc_cur_o;
    unique case (state_q)
      S_OP0, S_OP1: mem_req_o = 1'b1;
      S_PTR0: begin mem_req_o = 1'b1; mem_addr_o = ptr_lo_i; end
      S_PTR1: begin mem_req_o = 1'b1; mem_addr_o = ptr_hi_i; end
      default: ;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_FIN);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     pc_o
);
  logic [MODE_W-1:0] mode_q;
  am_ctl_t           ctl;
  logic [AW-1:0]     pc_start, pc_cur, ptr_lo, ptr_hi;
  logic [DW-1:0]     b0, b1, p0, p1, x_q, y_q;

  ea_mode_decode u_dec (
    .mode_i (mode_q),
    .ctl_o  (ctl)
  );

  ea_sequencer #(.DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .pc_i        (pc_i),
    .x_i         (x_i),
    .y_i         (y_i),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .ctl_i       (ctl),
    .ptr_lo_i    (ptr_lo),
    .ptr_hi_i    (ptr_hi),
    .mode_o      (mode_q),
    .pc_start_o  (pc_start),
    .pc_cur_o    (pc_cur),
    .b0_o        (b0),
    .b1_o        (b1),
    .p0_o        (p0),
    .p1_o        (p1),
    .x_o         (x_q),
    .y_o         (y_q),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  ea_addr_calc #(.DW(DW)) u_calc (
    .ctl_i      (ctl),
    .pc_start_i (pc_start),
    .pc_cur_i   (pc_cur),
    .b0_i       (b0),
    .b1_i       (b1),
    .p0_i       (p0),
    .p1_i       (p1),
    .x_i        (x_q),
    .y_i        (y_q),
    .ptr_lo_o   (ptr_lo),
    .ptr_hi_o   (ptr_hi),
    .ea_o       (ea_o)
  );

  assign pc_o = pc_cur;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MODE_W-1:0] mode_i,
  input logic [AW-1:0]     pc_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              mem_ready_i,
  input logic              done_o,
  input logic [AW-1:0]     ea_o,
  input logic [AW-1:0]     pc_o
);
  logic [MODE_W-1:0] c_mode;
  logic [AW-1:0]     c_pc;
  logic [AW-1:0]     c_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_mode <= '0;
      c_pc   <= '0;
    end else if (start_i && !busy_o) begin
      c_mode <= mode_i;
      c_pc   <= pc_i;
    end
  end

  assign c_len = (c_mode >= AM_ABS && c_mode <= AM_IND) ? AW'(2) : AW'(1);

  a_r10_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);

  a_r2_pc_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pc_o == AW'(c_pc + c_len));

  a_r4_zp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && (c_mode == AM_ZP || c_mode == AM_ZPX || c_mode == AM_ZPY)
      |-> ea_o[AW-1:DW] == '0);

  a_r5_imm_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && c_mode == AM_IMM |-> ea_o == c_pc);
endmodule

bind ea_unit ea_unit_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .pc_i        (pc_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .ea_o        (ea_o),
  .pc_o        (pc_o)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, y_i = '0;
  logic        busy_o, mem_req_o, mem_ready_i, done_o;
  logic [15:0] mem_addr_o, ea_o, pc_o;
  logic [7:0]  mem_rdata_i;
  logic        stall_en = 1'b0;
  logic [1:0]  ph = '0;
  int          n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  // memory model: byte at address a is a[7:0] ^ a[15:8]
  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  assign mem_rdata_i = mb(mem_addr_o);
  assign mem_ready_i = !stall_en || (ph == 2'd2);
  always @(negedge clk_i) ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;

  ea_unit u_dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x,
                       input logic [7:0] y, output logic [15:0] ea, output logic [15:0] npc,
                       output int beats);
    logic [7:0] b0, b1, z;
    logic [15:0] p;
    b0 = mb(pc);
    b1 = mb(pc + 16'd1);
    npc = pc + 16'd1;
    beats = 1;
    case (m)
      4'd1: ea = {8'h00, b0};
      4'd2: begin z = b0 + x; ea = {8'h00, z}; end
      4'd3: begin z = b0 + y; ea = {8'h00, z}; end
      4'd4, 4'd5, 4'd6, 4'd7: begin
        npc = pc + 16'd2;
        beats = 2;
        p = {b1, b0};
        if (m == 4'd5) ea = p + {8'h00, x};
        else if (m == 4'd6) ea = p + {8'h00, y};
        else if (m == 4'd7) begin ea = {mb(p + 16'd1), mb(p)}; beats = 4; end
        else ea = p;
      end
      4'd8, 4'd9: begin
        z = (m == 4'd8) ? b0 + x : b0;
        ea = {mb({8'h00, 8'(z + 8'd1)}), mb({8'h00, z})};
        if (m == 4'd9) ea = ea + {8'h00, y};
        beats = 3;
      end
      4'd10: ea = npc + {{8{b0[7]}}, b0};
      default: ea = pc;
    endcase
  endtask

  // start one operation, wait for done, compare results, latency and hold
  task automatic run(input string tag, input logic [3:0] m, input logic [15:0] pc,
                     input logic [7:0] x, input logic [7:0] y, input bit chk_lat);
    logic [15:0] e_ea, e_pc;
    int beats, n;
    model(m, pc, x, y, e_ea, e_pc, beats);
    mode_i = m; pc_i = pc; x_i = x; y_i = y; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 1;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    chk({tag, " done seen"}, 16'(done_o), 16'd1);
    chk({tag, " ea"}, ea_o, e_ea);
    chk({tag, " pc"}, pc_o, e_pc);
    if (chk_lat) chk({tag, " R11 latency"}, 16'(n), 16'(beats + 1));
    @(negedge clk_i);
    chk({tag, " R11 done single"}, 16'(done_o), 16'd0);
    chk({tag, " R11 ea held"}, ea_o, e_ea);
    chk({tag, " R11 pc held"}, pc_o, e_pc);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", 16'(busy_o), 16'd0);
    chk("R1 reset req", 16'(mem_req_o), 16'd0);
    chk("R1 reset done", 16'(done_o), 16'd0);
  endtask

  task automatic t_imm();
    run("R5 imm", 4'd0, 16'h0300, 8'h00, 8'h00, 1);
    run("R2 imm pc wrap", 4'd0, 16'hFFFF, 8'h00, 8'h00, 1);
  endtask

  task automatic t_zp();
    run("R4 zp", 4'd1, 16'h0412, 8'h00, 8'h00, 1);
    run("R4 zpx wrap", 4'd2, 16'h00FF, 8'h01, 8'h00, 1);
    run("R4 zpy", 4'd3, 16'h0412, 8'h00, 8'hF0, 1);
  endtask

  task automatic t_abs();
    run("R3 abs", 4'd4, 16'h2010, 8'h00, 8'h00, 1);
    run("R2 abs pc wrap", 4'd4, 16'hFFFE, 8'h00, 8'h00, 1);
    run("R3 absx wrap", 4'd5, 16'hFEFF, 8'hFF, 8'h00, 1);
    run("R3 absy", 4'd6, 16'h10EF, 8'h00, 8'h20, 1);
  endtask

  task automatic t_ind();
    run("R7 ind", 4'd7, 16'h3000, 8'h00, 8'h00, 1);
    run("R7 ind lo", 4'd7, 16'h00FF, 8'h00, 8'h00, 1);
  endtask

  task automatic t_izx();
    run("R8 izx zp wrap", 4'd8, 16'h0040, 8'hBF, 8'h00, 1);
    run("R8 izx", 4'd8, 16'h0510, 8'h07, 8'h00, 1);
  endtask

  task automatic t_izy();
    run("R9 izy zp wrap", 4'd9, 16'h00FF, 8'h00, 8'h01, 1);
    run("R9 izy 16b wrap", 4'd9, 16'h00FE, 8'h00, 8'h03, 1);
  endtask

  task automatic t_rel();
    run("R6 rel neg", 4'd10, 16'h00F0, 8'h00, 8'h00, 1);
    run("R6 rel pos", 4'd10, 16'h1234, 8'h00, 8'h00, 1);
    run("R6 rel pc wrap", 4'd10, 16'hFFFF, 8'h00, 8'h00, 1);
  endtask

  task automatic t_stall();
    stall_en = 1'b1;
    run("R10 stall izy", 4'd9, 16'h00FE, 8'h00, 8'h03, 0);
    run("R10 stall ind", 4'd7, 16'h3000, 8'h00, 8'h00, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_busy();
    logic [15:0] e_ea, e_pc;
    int beats;
    model(4'd8, 16'h0040, 8'hBF, 8'h00, e_ea, e_pc, beats);
    mode_i = 4'd8; pc_i = 16'h0040; x_i = 8'hBF; y_i = 8'h00; start_i = 1'b1;
    @(negedge clk_i);
    mode_i = 4'd0; pc_i = 16'h7777; x_i = 8'h00; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o) @(negedge clk_i);
    chk("R1 busy start ignored ea", ea_o, e_ea);
    chk("R1 busy start ignored pc", pc_o, e_pc);
    @(negedge clk_i);
    chk("R1 idle after", 16'(busy_o), 16'd0);
  endtask

  task automatic t_reserved();
    run("R12 code 13", 4'd13, 16'h4444, 8'h11, 8'h22, 1);
    run("R12 code 15", 4'd15, 16'hFFFF, 8'h00, 8'h00, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_imm();
    t_zp();
    t_abs();
    t_ind();
    t_izx();
    t_izy();
    t_rel();
    t_stall();
    t_busy();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule